// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two unsigned 32-bit operands over several clock cycles. It is built from one multiplicand register, one double-width product register and a single adder of operand width. A start pulse accepted while the block is idle captures the multiplicand. The same pulse places the multiplier in the lower half of the product register, and the upper half is cleared.

One step runs on each following clock. A step looks at the lowest product bit. When that bit is set, the multiplicand is added into the upper half. The whole product register then moves right by one place, and the adder's carry-out enters at the top. After exactly 32 steps the block drops busy, pulses done for one cycle and holds the 64-bit product until the next accepted start. While a multiplication is running, the start input and the operand inputs have no effect.

Top module: `seq_mul`

## Requirements
- R1: After synchronous reset, busy and done are 0 and product is all zeros.
- R2: A start pulse sampled while busy is 0 captures multiplicand and multiplier, and busy is 1 from the next cycle.
- R3: When done is 1, product equals the unsigned 64-bit product of the operands captured at the accepting start.
- R4: A multiplication takes exactly 32 step cycles. Busy stays 1 for 32 consecutive cycles, and done rises in the cycle after the last of them, with busy 0.
- R5: Done is high for exactly one cycle per multiplication.
- R6: A start pulse, or a change of the operand inputs, while busy is 1 is ignored. The running result and its timing are unchanged.
- R7: While busy is 0 and start is 0, product holds its value from cycle to cycle.
- R8: The carry out of each step's add is kept as the new top product bit, so all-ones times all-ones gives 0xFFFFFFFE00000001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a multiplication when idle |
| multiplicand | input | 32 | Unsigned operand added on each set bit |
| multiplier | input | 32 | Unsigned operand scanned from bit 0 upward |
| busy | output | 1 | Steps are in progress |
| done | output | 1 | One-cycle pulse when product is valid |
| product | output | 64 | Unsigned 64-bit result |

## Verification
The assertions assume that start is a clean synchronous level that is never X after reset. They also assume that the operands only matter in the cycle that start is accepted, since the checker records them exactly there. The stimulus drives every input on the falling clock edge, holds start high for a single cycle per request, and reuses an accepted request's timing when it injects a stray start and new operand values mid-run. Operand pairs come from a fixed-seed random source mixed with zero, one, all-ones and single-bit corner values.

// File: rtl/mul_pkg.sv
package mul_pkg;

    localparam int unsigned MUL_W = 32;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } mul_state_e;

    function automatic int unsigned cnt_bits(input int unsigned w);
        return (w > 1) ? $clog2(w) : 1;
    endfunction

endpackage

// File: rtl/mul_ctrl.sv
module mul_ctrl
    import mul_pkg::*;
#(
    parameter int unsigned W = MUL_W
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic load,
    output logic step,
    output logic busy,
    output logic done
);
    localparam int unsigned CW = cnt_bits(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    mul_state_e      state_q;
    logic [CW-1:0]   iter_q;
    logic            done_q;

    assign load = (state_q == ST_IDLE) && start;
    assign step = (state_q == ST_RUN);
    assign busy = (state_q == ST_RUN);
    assign done = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            iter_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_RUN;
                        iter_q  <= '0;
                    end
                end
                ST_RUN: begin
                    if (iter_q == LAST) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end
                    iter_q <= iter_q + 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/mul_datapath.sv
module mul_datapath
    import mul_pkg::*;
#(
    parameter int unsigned W = MUL_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic           step,
    input  logic [W-1:0]   mcand_in,
    input  logic [W-1:0]   mplier_in,
    output logic [2*W-1:0] prod
);
    logic [W-1:0]   mcand_q;
    logic [2*W-1:0] prod_q;
    logic [W:0]     hi_sum;
    logic [W-1:0]   addend;

    assign addend = prod_q[0] ? mcand_q : '0;
    assign hi_sum = {1'b0, prod_q[2*W-1:W]} + {1'b0, addend};
    assign prod   = prod_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mcand_q <= '0;
            prod_q  <= '0;
        end else if (load) begin
            mcand_q <= mcand_in;
            prod_q  <= {{W{1'b0}}, mplier_in};
        end else if (step) begin
            prod_q  <= {hi_sum, prod_q[W-1:1]};
        end
    end
endmodule

// File: rtl/seq_mul.sv
module seq_mul
    import mul_pkg::*;
#(
    parameter int unsigned W = MUL_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [W-1:0]   multiplicand,
    input  logic [W-1:0]   multiplier,
    output logic           busy,
    output logic           done,
    output logic [2*W-1:0] product
);
    logic load, step;

    mul_ctrl #(.W(W)) u_ctrl (
        .clk  (clk),
        .rst  (rst),
        .start(start),
        .load (load),
        .step (step),
        .busy (busy),
        .done (done)
    );

    mul_datapath #(.W(W)) u_dp (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .step     (step),
        .mcand_in (multiplicand),
        .mplier_in(multiplier),
        .prod     (product)
    );
endmodule

// File: rtl/mul_chk.sv
module mul_chk
    import mul_pkg::*;
#(
    parameter int unsigned W = MUL_W
) (
    input logic           clk,
    input logic           rst,
    input logic           start,
    input logic [W-1:0]   multiplicand,
    input logic [W-1:0]   multiplier,
    input logic           busy,
    input logic           done,
    input logic [2*W-1:0] product
);
    localparam int unsigned RW = cnt_bits(W) + 1;

    logic [RW-1:0]  run_len;
    logic [W-1:0]   cap_a, cap_b;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_len <= '0;
            cap_a   <= '0;
            cap_b   <= '0;
        end else begin
            run_len <= busy ? run_len + 1'b1 : '0;
            if (!busy && start) begin
                cap_a <= multiplicand;
                cap_b <= multiplier;
            end
        end
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        $past(rst) |-> (!busy && !done && product == '0));

    assert_start_accept_R2: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> busy);

    assert_result_R3: assert property (@(posedge clk) disable iff (rst)
        done |-> (product == ({{W{1'b0}}, cap_a} * {{W{1'b0}}, cap_b})));

    assert_run_bound_R4: assert property (@(posedge clk) disable iff (rst)
        busy |-> (run_len < RW'(W)));

    assert_run_length_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (done && $past(run_len) == RW'(W - 1)));

    assert_done_idle_R4: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(product));
endmodule

bind seq_mul mul_chk #(.W(W)) u_mul_chk (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .multiplicand(multiplicand),
    .multiplier  (multiplier),
    .busy        (busy),
    .done        (done),
    .product     (product)
);

// File: tb/tb_seq_mul.sv
module tb_seq_mul;
    localparam int W = 32;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           start = 1'b0;
    logic [W-1:0]   multiplicand = '0;
    logic [W-1:0]   multiplier = '0;
    logic           busy, done;
    logic [2*W-1:0] product;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    seq_mul #(.W(W)) dut (
        .clk(clk), .rst(rst), .start(start),
        .multiplicand(multiplicand), .multiplier(multiplier),
        .busy(busy), .done(done), .product(product)
    );

    function automatic logic [2*W-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
        return {{W{1'b0}}, a} * {{W{1'b0}}, b};
    endfunction

    task automatic chk(input string req, input logic [2*W-1:0] act, input logic [2*W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Runs one multiplication; optional stray start and operand change at cycle 5.
    task automatic run_mul(input logic [W-1:0] a, input logic [W-1:0] b, input bit disturb);
        int lat;
        int busy_cnt;
        logic [2*W-1:0] held;
        @(negedge clk);
        multiplicand = a;
        multiplier   = b;
        start        = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R2 busy after start", {63'd0, busy}, 64'd1);
        lat = 1;
        busy_cnt = 1;
        while (!done && lat < 100) begin
            if (disturb && lat == 5) begin
                start        = 1'b1;
                multiplicand = ~a;
                multiplier   = b ^ 32'h5A5A_5A5A;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            lat++;
            if (busy) busy_cnt++;
        end
        start = 1'b0;
        chk(disturb ? "R6 latency with stray start" : "R4 done latency", 64'(lat), 64'd33);
        chk("R4 busy length", 64'(busy_cnt), 64'd32);
        chk("R4 busy low at done", {63'd0, busy}, 64'd0);
        chk(disturb ? "R6 result with stray start" : "R3 product", product, ref_mul(a, b));
        held = product;
        @(negedge clk);
        chk("R5 done single cycle", {63'd0, done}, 64'd0);
        multiplicand = $urandom;
        multiplier   = $urandom;
        repeat (3) @(negedge clk);
        chk("R7 product held while idle", product, held);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000 && !finished) begin
            finished = 1'b1;
            failures++;
            $display("FAIL watchdog actual=%0d expected<=200000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(1234);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 busy at reset", {63'd0, busy}, 64'd0);
        chk("R1 done at reset", {63'd0, done}, 64'd0);
        chk("R1 product at reset", product, 64'd0);

        run_mul(32'd0, 32'd0, 1'b0);
        run_mul(32'hFFFF_FFFF, 32'd0, 1'b0);
        run_mul(32'd0, 32'hFFFF_FFFF, 1'b0);
        run_mul(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
        chk("R8 all-ones carry", product, 64'hFFFF_FFFE_0000_0001);
        run_mul(32'd1, 32'hDEAD_BEEF, 1'b0);
        run_mul(32'h8000_0000, 32'h8000_0000, 1'b0);
        run_mul(32'h1234_5678, 32'h9ABC_DEF0, 1'b1);
        for (int i = 0; i < 24; i++) begin
            run_mul($urandom, $urandom, (i % 6) == 0);
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule